// File: doc/BRIEF.md
# Multiframe maintenance-bit status and transmit buffer

This block sits beside a framed line interface. It holds the maintenance bits that travel once per multiframe. On the receive side it keeps the five most recent S bits. It also keeps three event flags: new S data has arrived, the transmit Q buffer has run empty, and the multiframe state has changed. Software reads all of this as one status byte. Reading the byte clears the two event flags that report something new. Each event flag can drive a shared interrupt line through its own enable input.

On the transmit side, software writes a byte that carries four Q bits and one fallback Q value. While multiframing is on and the line is synchronised, the framer takes the Q bits one at a time through a request strobe. While multiframing is on but not yet synchronised, the fallback value is sent instead. When multiframing is off, the output idles high.

The framer, the synchronisation detector and the interrupt controller are outside this block. They appear here only as strobes and level inputs.

Top module: `mfsq_maint_buf`

## Requirements
- R1: After reset the status byte reads 0x40 and the interrupt output is low when all enables are 0. Q1 to Q4 reset to 1 and the fallback value resets to 0.
- R2: A pulse on `mf_end` copies `sbit_in[4:0]` into status bits 4..0 and sets status bit 5 (new S data). Both take effect at the next clock edge.
- R3: A read with `bus_addr`=0 returns the status byte on `bus_rdata` one cycle later and clears status bits 5 and 7. Bits 0 to 4 and bit 6 keep their values. If a setting event arrives in the same cycle as the read, the flag ends up set.
- R4: A pulse on `mf_chg` sets status bit 7 (multiframe state changed).
- R5: A write with `bus_addr`=1 loads Q1..Q4 from data bits 0..3 and the fallback value from data bit 4. Data bits 7..5 have no effect. The write clears status bit 6 and restarts transmission at Q1.
- R6: While `mf_on`=1 and `mf_sync`=1, `q_out` shows the current Q bit, starting at Q1. Each `q_req` moves on to the next bit. After Q4 it wraps back to Q1, and the fourth request sets status bit 6 (buffer empty).
- R7: While `mf_on`=1 and `mf_sync`=0, `q_out` equals the fallback value. While `mf_on`=0, `q_out` is 1. In both cases `q_req` does not move the bit position.
- R8: `irq` is high exactly when at least one of these holds: status bit 5 is set with `irq_en[0]`, status bit 6 is set with `irq_en[1]`, or status bit 7 is set with `irq_en[2]`. Status bits 0 to 4 never raise it.
- R9: A read with `bus_addr`=1 returns 0x00. A write with `bus_addr`=0 changes neither the status byte nor the Q buffer.
- R10: If a Q write lands in the same cycle as the fourth `q_req`, the write wins: bit 6 ends clear and transmission restarts at Q1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | 0 selects the status byte, 1 selects the Q buffer |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| sbit_in | input | 5 | S1..S5 gathered over the last multiframe |
| mf_end | input | 1 | End-of-multiframe strobe that captures S bits |
| mf_chg | input | 1 | Multiframe state change strobe |
| mf_on | input | 1 | Multiframing enabled |
| mf_sync | input | 1 | Multiframe synchronisation achieved |
| q_req | input | 1 | Framer takes one Q bit |
| q_out | output | 1 | Q bit currently presented to the framer |
| irq_en | input | 3 | Interrupt enables for status bits 5, 6, 7 |
| irq | output | 1 | Combined interrupt request |

## Verification
The properties assume that every strobe (`bus_rd`, `bus_wr`, `mf_end`, `mf_chg`, `q_req`) is a single-cycle pulse sampled on the clock. They also assume that read data is only examined in the cycle after a read. The clear-on-read property applies only when no setting event coincides with the read. The bench drives each strobe for exactly one clock from the falling edge. It exercises the coincident cases (read with `mf_end`, write with the last `q_req`) as directed tests with their own expected values. The inputs `mf_on`, `mf_sync` and `irq_en` change only between strobes.

// File: rtl/mfsq_pkg.sv
package mfsq_pkg;

    localparam int DATA_W  = 8;
    localparam int S_CNT   = 5;
    localparam int Q_CNT   = 4;
    localparam int EVT_CNT = 3;
    localparam int QIDX_W  = (Q_CNT > 1) ? $clog2(Q_CNT) : 1;

    // Status byte layout: event flags on top, received S bits below
    typedef struct packed {
        logic             chg;
        logic             q_empty;
        logic             s_new;
        logic [S_CNT-1:0] s_bits;
    } mf_status_t;

    // Transmit buffer contents
    typedef struct packed {
        logic             fallback;
        logic [Q_CNT-1:0] q;
    } qbuf_t;

    typedef enum logic {
        ADDR_STATUS = 1'b0,
        ADDR_QBUF   = 1'b1
    } reg_addr_t;

    typedef enum logic [1:0] {
        TX_IDLE     = 2'd0,
        TX_FALLBACK = 2'd1,
        TX_SHIFT    = 2'd2
    } tx_mode_t;

    localparam qbuf_t QBUF_RST = '{fallback: 1'b0, q: {Q_CNT{1'b1}}};

    function automatic tx_mode_t pick_tx_mode(input logic on, input logic sync);
        if (!on)
            return TX_IDLE;
        else if (!sync)
            return TX_FALLBACK;
        else
            return TX_SHIFT;
    endfunction

endpackage

// File: rtl/mfsq_rx_status.sv
module mfsq_rx_status
    import mfsq_pkg::*;
#(
    parameter int NS = S_CNT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NS-1:0] s_in,
    input  logic          cap_stb,
    input  logic          chg_stb,
    input  logic          rd_clr,
    output logic [NS-1:0] s_bits,
    output logic          s_new,
    output logic          chg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            s_bits <= '0;
            s_new  <= 1'b0;
            chg    <= 1'b0;
        end else begin
            if (cap_stb)
                s_bits <= s_in;
            // a new event always beats a clearing read in the same cycle
            s_new <= cap_stb | (s_new & ~rd_clr);
            chg   <= chg_stb | (chg & ~rd_clr);
        end
    end

endmodule

// File: rtl/mfsq_tx_qbuf.sv
module mfsq_tx_qbuf
    import mfsq_pkg::*;
#(
    parameter int NQ = Q_CNT
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  qbuf_t      load_val,
    input  tx_mode_t   mode,
    input  logic       take,
    output logic       bit_out,
    output logic       empty
);

    localparam int IW = (NQ > 1) ? $clog2(NQ) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(NQ - 1);

    qbuf_t         buf_q;
    logic [IW-1:0] idx;
    logic          advance;
    logic          at_last;

    assign advance = take && (mode == TX_SHIFT);
    assign at_last = (idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q <= QBUF_RST;
            idx   <= '0;
            empty <= 1'b1;
        end else if (load) begin
            buf_q <= load_val;
            idx   <= '0;
            empty <= 1'b0;
        end else if (advance) begin
            idx <= at_last ? '0 : idx + 1'b1;
            if (at_last)
                empty <= 1'b1;
        end
    end

    always_comb begin
        unique case (mode)
            TX_SHIFT:    bit_out = buf_q.q[idx];
            TX_FALLBACK: bit_out = buf_q.fallback;
            default:     bit_out = 1'b1;
        endcase
    end

endmodule

// File: rtl/mfsq_irq_merge.sv
module mfsq_irq_merge #(
    parameter int NE = 3
) (
    input  logic [NE-1:0] flags,
    input  logic [NE-1:0] enables,
    output logic          req
);

    logic [NE-1:0] gated;

    genvar g;
    generate
        for (g = 0; g < NE; g++) begin : g_evt
            assign gated[g] = flags[g] & enables[g];
        end
    endgenerate

    assign req = |gated;

endmodule

// File: rtl/mfsq_maint_buf.sv
module mfsq_maint_buf
    import mfsq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [S_CNT-1:0]  sbit_in,
    input  logic              mf_end,
    input  logic              mf_chg,
    input  logic              mf_on,
    input  logic              mf_sync,
    input  logic              q_req,
    output logic              q_out,
    input  logic [EVT_CNT-1:0] irq_en,
    output logic              irq
);

    mf_status_t status;
    logic       rd_status;
    logic       rd_qbuf;
    logic       wr_qbuf;
    qbuf_t      wr_val;
    tx_mode_t   mode;
    logic [S_CNT-1:0] s_bits;
    logic       s_new;
    logic       chg;
    logic       q_empty;

    assign rd_status = bus_rd && (reg_addr_t'(bus_addr) == ADDR_STATUS);
    assign rd_qbuf   = bus_rd && (reg_addr_t'(bus_addr) == ADDR_QBUF);
    assign wr_qbuf   = bus_wr && (reg_addr_t'(bus_addr) == ADDR_QBUF);
    assign wr_val    = qbuf_t'(bus_wdata[S_CNT-1:0]);
    assign mode      = pick_tx_mode(mf_on, mf_sync);

    mfsq_rx_status #(.NS(S_CNT)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .s_in    (sbit_in),
        .cap_stb (mf_end),
        .chg_stb (mf_chg),
        .rd_clr  (rd_status),
        .s_bits  (s_bits),
        .s_new   (s_new),
        .chg     (chg)
    );

    mfsq_tx_qbuf #(.NQ(Q_CNT)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .load     (wr_qbuf),
        .load_val (wr_val),
        .mode     (mode),
        .take     (q_req),
        .bit_out  (q_out),
        .empty    (q_empty)
    );

    assign status = '{chg: chg, q_empty: q_empty, s_new: s_new, s_bits: s_bits};

    mfsq_irq_merge #(.NE(EVT_CNT)) u_irq (
        .flags   ({status.chg, status.q_empty, status.s_new}),
        .enables (irq_en),
        .req     (irq)
    );

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (rd_status)
            bus_rdata <= status;
        else if (rd_qbuf)
            bus_rdata <= '0;
    end

endmodule

// File: rtl/mfsq_maint_buf_chk.sv
module mfsq_maint_buf_chk
    import mfsq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [S_CNT-1:0]  sbit_in,
    input logic              mf_end,
    input logic              mf_chg,
    input logic [EVT_CNT-1:0] irq_en,
    input logic              irq,
    input logic [DATA_W-1:0] stat_bits
);

    // R2: captured S bits and new-data flag follow an end strobe
    p_sbit_capture_r2: assert property (@(posedge clk) disable iff (rst)
        mf_end |=> (stat_bits[4:0] == $past(sbit_in)) && stat_bits[5]);

    // R3: a status read with no coincident event leaves bits 5 and 7 clear
    p_read_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_addr && !mf_end && !mf_chg) |=> !stat_bits[5] && !stat_bits[7]);

    // R3: read data equals the status byte seen at the read
    p_read_value_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_addr) |=> bus_rdata == $past(stat_bits));

    // R4: change strobe sets bit 7
    p_chg_sets_r4: assert property (@(posedge clk) disable iff (rst)
        mf_chg |=> stat_bits[7]);

    // R5: Q buffer write clears the empty flag
    p_write_clears_empty_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr) |=> !stat_bits[6]);

    // R8: no enable, no interrupt
    p_irq_masked_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_en == '0) |-> !irq);

    // R9: reading the write-only buffer yields zero
    p_qbuf_reads_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr) |=> bus_rdata == '0);

    // R9: writing the status address does not disturb held S bits
    p_status_write_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_addr && !mf_end) |=> $stable(stat_bits[4:0]));

endmodule

bind mfsq_maint_buf mfsq_maint_buf_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .sbit_in   (sbit_in),
    .mf_end    (mf_end),
    .mf_chg    (mf_chg),
    .irq_en    (irq_en),
    .irq       (irq),
    .stat_bits (status)
);

// File: tb/mfsq_maint_buf_bench.sv
module mfsq_maint_buf_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       bus_addr;
    logic       bus_rd;
    logic       bus_wr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic [4:0] sbit_in;
    logic       mf_end;
    logic       mf_chg;
    logic       mf_on;
    logic       mf_sync;
    logic       q_req;
    logic       q_out;
    logic [2:0] irq_en;
    logic       irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    mfsq_maint_buf u_mfsq_maint_buf (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sbit_in   (sbit_in),
        .mf_end    (mf_end),
        .mf_chg    (mf_chg),
        .mf_on     (mf_on),
        .mf_sync   (mf_sync),
        .q_req     (q_req),
        .q_out     (q_out),
        .irq_en    (irq_en),
        .irq       (irq)
    );

    // {sbits[4:0], chg, expected status byte}
    localparam logic [13:0] VEC [6] = '{
        {5'h00, 1'b0, 8'h60},
        {5'h1F, 1'b1, 8'hFF},
        {5'h15, 1'b0, 8'h75},
        {5'h0A, 1'b1, 8'hEA},
        {5'h13, 1'b0, 8'h73},
        {5'h04, 1'b1, 8'hE4}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic step;
        @(negedge clk);
    endtask

    task automatic read_reg(input logic a, output logic [7:0] v);
        bus_addr = a; bus_rd = 1'b1;
        step();
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic write_reg(input logic a, input logic [7:0] d);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic take_q;
        q_req = 1'b1;
        step();
        q_req = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        rst = 1'b1; bus_addr = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        sbit_in = '0; mf_end = 1'b0; mf_chg = 1'b0; mf_on = 1'b0; mf_sync = 1'b0;
        q_req = 1'b0; irq_en = '0;
        step(); step(); step();
        rst = 1'b0;
        step();

        // R1 reset state
        check("R1 irq low", {7'd0, irq}, 8'h00);
        mf_on = 1'b1; mf_sync = 1'b1;
        #1 check("R1 Q1 default", {7'd0, q_out}, 8'h01);
        mf_sync = 1'b0;
        #1 check("R1 fallback default", {7'd0, q_out}, 8'h00);
        mf_on = 1'b0;
        read_reg(1'b0, v);
        check("R1 status reset", v, 8'h40);

        // R2 R3 R4 vector walk
        foreach (VEC[i]) begin
            sbit_in = VEC[i][13:9]; mf_end = 1'b1; mf_chg = VEC[i][8];
            step();
            mf_end = 1'b0; mf_chg = 1'b0;
            read_reg(1'b0, v);
            check("R2 R4 capture", v, VEC[i][7:0]);
            read_reg(1'b0, v);
            check("R3 clear on read", v, VEC[i][7:0] & 8'h5F);
        end

        // R5 write Q buffer, upper bits ignored
        write_reg(1'b1, 8'hE5);
        read_reg(1'b0, v);
        check("R5 empty cleared", v, 8'h04);

        // R6 shifting order and empty after fourth bit
        mf_on = 1'b1; mf_sync = 1'b1;
        #1 check("R6 Q1", {7'd0, q_out}, 8'h01);
        take_q();
        check("R6 Q2", {7'd0, q_out}, 8'h00);
        take_q();
        check("R6 Q3", {7'd0, q_out}, 8'h01);
        take_q();
        check("R6 Q4", {7'd0, q_out}, 8'h00);
        read_reg(1'b0, v);
        check("R6 not empty after three", v, 8'h04);
        take_q();
        check("R6 wrap to Q1", {7'd0, q_out}, 8'h01);
        read_reg(1'b0, v);
        check("R6 empty after four", v, 8'h44);

        // R7 fallback and idle, no advance
        write_reg(1'b1, 8'h10);
        mf_sync = 1'b0;
        #1 check("R7 fallback value", {7'd0, q_out}, 8'h01);
        take_q(); take_q();
        mf_on = 1'b0;
        #1 check("R7 idle high", {7'd0, q_out}, 8'h01);
        take_q();
        mf_on = 1'b1; mf_sync = 1'b1;
        #1 check("R7 still at Q1", {7'd0, q_out}, 8'h00);
        read_reg(1'b0, v);
        check("R7 no empty from ignored takes", v, 8'h04);

        // R8 interrupt gating
        mf_chg = 1'b1;
        step();
        mf_chg = 1'b0;
        check("R8 masked", {7'd0, irq}, 8'h00);
        irq_en = 3'b011;
        #1 check("R8 S bits and other flags off", {7'd0, irq}, 8'h00);
        irq_en = 3'b100;
        #1 check("R8 chg enabled", {7'd0, irq}, 8'h01);
        read_reg(1'b0, v);
        check("R8 after clear", {7'd0, irq}, 8'h00);
        irq_en = 3'b001;
        sbit_in = 5'h00; mf_end = 1'b1;
        step();
        mf_end = 1'b0;
        check("R8 s_new enabled", {7'd0, irq}, 8'h01);
        read_reg(1'b0, v);
        irq_en = 3'b000;

        // R9 unused directions
        write_reg(1'b0, 8'hFF);
        read_reg(1'b1, v);
        check("R9 Q buffer reads zero", v, 8'h00);
        read_reg(1'b0, v);
        check("R9 status unchanged", v, 8'h00);
        #1 check("R9 Q buffer unchanged", {7'd0, q_out}, 8'h00);

        // R10 write beats final take
        write_reg(1'b1, 8'h0F);
        take_q(); take_q(); take_q();
        q_req = 1'b1; bus_addr = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h01;
        step();
        q_req = 1'b0; bus_wr = 1'b0;
        check("R10 restart at Q1", {7'd0, q_out}, 8'h01);
        read_reg(1'b0, v);
        check("R10 empty clear", v, 8'h00);
        take_q();
        check("R10 then Q2", {7'd0, q_out}, 8'h00);

        // R3 event coincident with read
        sbit_in = 5'h09; mf_end = 1'b1; bus_addr = 1'b0; bus_rd = 1'b1;
        step();
        mf_end = 1'b0; bus_rd = 1'b0;
        check("R3 read returns old", bus_rdata, 8'h00);
        read_reg(1'b0, v);
        check("R3 coincident event kept", v, 8'h29);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule